// File: doc/BRIEF.md
# Indicator-Gated Oldest-First Issue Select

This block is the select stage of an out-of-order issue queue in which pairs of functional units share one result-tag broadcast line. Each cycle the queue presents one request bit per entry, where entry 0 is the oldest, and one type bit per entry that marks instructions that write a register and so produce a wakeup tag. The block also sees one waiting-tag indicator per functional unit. An indicator is set when that unit's tag latch still holds a tag that lost the shared line in an earlier cycle. From these inputs it picks at most one entry for each functional unit and registers the grants for the execute stage.

Functional units are served in a fixed order, from unit 0 upward. Each unit takes the oldest eligible request that no lower-numbered unit has already taken. Eligibility depends on a run-time gating mode:
- **Plain mode:** a unit with a waiting tag takes nothing.
- **Slot-reuse mode:** such a unit may still take an instruction that produces no tag.
- **Tag-limit mode:** in addition to the slot-reuse rule, the number of tag producers granted to each unit pair is capped by a budget. The budget is derived from the waiting tags in that pair and the `MAX_WAIT` parameter.

Top module: `rws_issue_select`

## Requirements
- R1: The grant outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges. While `rst_n` is low at a rising edge, all grant outputs become 0.
- R2: When `issue_en` is 0, or no bit of `req_vec` is set, no grant is issued. A unit with `gnt_valid` low reports index 0 in its `gnt_idx` field.
- R3: Every grant names an entry whose `req_vec` bit is set, and no entry is granted to more than one functional unit in the same cycle.
- R4: Units are served in increasing index order. Each unit takes the lowest-index eligible entry not already taken by a lower unit. A unit with no eligible entry is skipped, and later units are still served. Unit f's index occupies `gnt_idx[f*IDXW +: IDXW]`.
- R5: With `gate_mode` 0 (plain) or 3 (treated as plain), a unit whose `wait_ind` bit is 1 receives no grant, whatever the type of the requests.
- R6: With `gate_mode` 1 (slot reuse), a unit whose `wait_ind` bit is 1 may be granted only entries whose `prod_tag` bit is 0. `prod_tag` = 1 means the instruction produces a tag. A unit whose `wait_ind` bit is 0 may take any entry.
- R7: With `gate_mode` 2 (tag limit), group g contains units g*GROUP_SZ to g*GROUP_SZ+GROUP_SZ-1. The group's tag budget is max(0, MAX_WAIT+1 − number of set `wait_ind` bits in the group). The slot-reuse rule of R6 still applies. The budget is spent in unit order, and the number of tag-producing grants in the group never exceeds the budget. Non-producing entries are not limited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_en | input | 1 | Global select enable |
| gate_mode | input | 2 | 0 plain, 1 slot reuse, 2 tag limit, 3 as plain |
| wait_ind | input | ISSUE_W | Waiting-tag indicator per functional unit |
| req_vec | input | N_ENTRY | Request per queue entry, index 0 oldest |
| prod_tag | input | N_ENTRY | 1 when the entry's instruction produces a tag |
| gnt_valid | output | ISSUE_W | Registered grant valid per functional unit |
| gnt_idx | output | ISSUE_W*IDXW | Registered granted entry index per unit, IDXW = clog2(N_ENTRY) |

## Verification
The bench builds the block with an 8-entry queue, six units in three pairs, and `MAX_WAIT` = 0.

With eight entries, the corner where requests run out before the units do is easy to reach. The indices also stay short enough to compute by hand.

`MAX_WAIT` = 0 gives each idle pair a budget of a single tag producer. The tag-limit mode then visibly differs from slot-reuse mode; with a budget of two, the indicators alone would already enforce the same limit.

// File: rtl/rws_sel_pkg.sv
package rws_sel_pkg;

    typedef enum logic [1:0] {
        GM_PLAIN  = 2'd0,
        GM_SLOT   = 2'd1,
        GM_TAGLIM = 2'd2,
        GM_RSVD   = 2'd3
    } gate_mode_e;

endpackage

// File: rtl/rws_grp_budget.sv
module rws_grp_budget #(
    parameter int GROUP_SZ = 2,
    parameter int MAX_WAIT = 1,
    parameter int BW       = 3
) (
    input  logic [GROUP_SZ-1:0] grp_ind,
    output logic [BW-1:0]       budget
);
    localparam int LIMIT = MAX_WAIT + 1;

    int unsigned busy;

    always_comb begin
        busy = $countones(grp_ind);
        if (busy >= LIMIT) begin
            budget = '0;
        end else begin
            budget = BW'(LIMIT - busy);
        end
    end

endmodule

// File: rtl/rws_fu_pick.sv
module rws_fu_pick
    import rws_sel_pkg::*;
#(
    parameter int N_ENTRY = 32,
    parameter int IDXW    = 5
) (
    input  gate_mode_e         mode,
    input  logic               unit_busy,
    input  logic               budget_ok,
    input  logic [N_ENTRY-1:0] avail,
    input  logic [N_ENTRY-1:0] prod,
    output logic [N_ENTRY-1:0] pick_oh,
    output logic               pick_vld,
    output logic [IDXW-1:0]    pick_idx,
    output logic               pick_tag
);
    logic [N_ENTRY-1:0] allow;
    logic [N_ENTRY-1:0] elig;

    // eligibility per entry under the active gating mode
    always_comb begin
        for (int e = 0; e < N_ENTRY; e++) begin
            unique case (mode)
                GM_SLOT:   allow[e] = !unit_busy || !prod[e];
                GM_TAGLIM: allow[e] = !prod[e] || (!unit_busy && budget_ok);
                default:   allow[e] = !unit_busy;
            endcase
        end
        elig = avail & allow;
    end

    // lowest index wins: isolate the least significant set bit
    always_comb begin
        pick_oh  = elig & (~elig + N_ENTRY'(1));
        pick_vld = |elig;
        pick_tag = |(pick_oh & prod);
        pick_idx = '0;
        for (int e = 0; e < N_ENTRY; e++) begin
            if (pick_oh[e]) begin
                pick_idx = IDXW'(e);
            end
        end
    end

endmodule

// File: rtl/rws_issue_select.sv
module rws_issue_select
    import rws_sel_pkg::*;
#(
    parameter int N_ENTRY  = 32,
    parameter int ISSUE_W  = 6,
    parameter int GROUP_SZ = 2,
    parameter int MAX_WAIT = 1,
    localparam int IDXW    = $clog2(N_ENTRY),
    localparam int N_GRP   = ISSUE_W / GROUP_SZ,
    localparam int BW      = $clog2(MAX_WAIT + GROUP_SZ + 2)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue_en,
    input  logic [1:0]              gate_mode,
    input  logic [ISSUE_W-1:0]      wait_ind,
    input  logic [N_ENTRY-1:0]      req_vec,
    input  logic [N_ENTRY-1:0]      prod_tag,
    output logic [ISSUE_W-1:0]      gnt_valid,
    output logic [ISSUE_W*IDXW-1:0] gnt_idx
);
    gate_mode_e         mode;
    logic [N_ENTRY-1:0] taken   [0:ISSUE_W];
    logic [N_ENTRY-1:0] pick_oh [0:ISSUE_W-1];
    logic [BW-1:0]      bud     [0:ISSUE_W-1];
    logic [BW-1:0]      grp_bud [0:N_GRP-1];
    logic [ISSUE_W-1:0] tag_used;
    logic [ISSUE_W-1:0] vld_c;
    logic [ISSUE_W*IDXW-1:0] idx_c;

    assign mode     = gate_mode_e'(gate_mode);
    assign taken[0] = '0;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        rws_grp_budget #(
            .GROUP_SZ(GROUP_SZ),
            .MAX_WAIT(MAX_WAIT),
            .BW      (BW)
        ) u_bud (
            .grp_ind(wait_ind[g*GROUP_SZ +: GROUP_SZ]),
            .budget (grp_bud[g])
        );
    end

    for (genvar f = 0; f < ISSUE_W; f++) begin : g_fu
        // budget chain: restart at the first unit of each group
        if ((f % GROUP_SZ) == 0) begin : g_head
            assign bud[f] = grp_bud[f / GROUP_SZ];
        end else begin : g_tail
            assign bud[f] = bud[f-1] - BW'(tag_used[f-1]);
        end

        rws_fu_pick #(
            .N_ENTRY(N_ENTRY),
            .IDXW   (IDXW)
        ) u_pick (
            .mode     (mode),
            .unit_busy(wait_ind[f]),
            .budget_ok(bud[f] != '0),
            .avail    (req_vec & ~taken[f] & {N_ENTRY{issue_en}}),
            .prod     (prod_tag),
            .pick_oh  (pick_oh[f]),
            .pick_vld (vld_c[f]),
            .pick_idx (idx_c[f*IDXW +: IDXW]),
            .pick_tag (tag_used[f])
        );

        assign taken[f+1] = taken[f] | pick_oh[f];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid <= '0;
            gnt_idx   <= '0;
        end else begin
            gnt_valid <= vld_c;
            gnt_idx   <= idx_c;
        end
    end

endmodule

// File: rtl/rws_sel_chk.sv
module rws_sel_chk #(
    parameter int N_ENTRY  = 32,
    parameter int ISSUE_W  = 6,
    parameter int GROUP_SZ = 2,
    parameter int MAX_WAIT = 1,
    parameter int IDXW     = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    issue_en,
    input logic [1:0]              gate_mode,
    input logic [ISSUE_W-1:0]      wait_ind,
    input logic [N_ENTRY-1:0]      req_vec,
    input logic [N_ENTRY-1:0]      prod_tag,
    input logic [ISSUE_W-1:0]      gnt_valid,
    input logic [ISSUE_W*IDXW-1:0] gnt_idx
);
    localparam int N_GRP = ISSUE_W / GROUP_SZ;

    logic               en_q;
    logic [1:0]         mode_q;
    logic [ISSUE_W-1:0] ind_q;
    logic [N_ENTRY-1:0] req_q;
    logic [N_ENTRY-1:0] prod_q;
    int unsigned        tag_cnt [0:N_GRP-1];
    int unsigned        ind_cnt [0:N_GRP-1];

    always_ff @(posedge clk) begin
        en_q   <= issue_en;
        mode_q <= gate_mode;
        ind_q  <= wait_ind;
        req_q  <= req_vec;
        prod_q <= prod_tag;
    end

    always_comb begin
        for (int g = 0; g < N_GRP; g++) begin
            tag_cnt[g] = 0;
            ind_cnt[g] = 0;
            for (int k = 0; k < GROUP_SZ; k++) begin
                if (gnt_valid[g*GROUP_SZ+k] &&
                    prod_q[gnt_idx[(g*GROUP_SZ+k)*IDXW +: IDXW]]) begin
                    tag_cnt[g] = tag_cnt[g] + 1;
                end
                if (ind_q[g*GROUP_SZ+k]) begin
                    ind_cnt[g] = ind_cnt[g] + 1;
                end
            end
        end
    end

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q || req_q == '0) |-> (gnt_valid == '0)); // R2

    for (genvar f = 0; f < ISSUE_W; f++) begin : g_fu_chk
        AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_valid[f] |-> req_q[gnt_idx[f*IDXW +: IDXW]]); // R3
        AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !gnt_valid[f] |-> (gnt_idx[f*IDXW +: IDXW] == '0)); // R2
        AST_PLAIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            ((mode_q == 2'd0 || mode_q == 2'd3) && ind_q[f]) |-> !gnt_valid[f]); // R5
        AST_NO_TAG_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (ind_q[f] && gnt_valid[f]) |-> !prod_q[gnt_idx[f*IDXW +: IDXW]]); // R6
        for (genvar h = f + 1; h < ISSUE_W; h++) begin : g_pair
            AST_DISTINCT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt_valid[f] && gnt_valid[h]) |->
                (gnt_idx[f*IDXW +: IDXW] != gnt_idx[h*IDXW +: IDXW])); // R3
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp_chk
        AST_TAG_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q == 2'd2) |->
            (tag_cnt[g] == 0 || tag_cnt[g] + ind_cnt[g] <= MAX_WAIT + 1)); // R7
    end

endmodule

bind rws_issue_select rws_sel_chk #(
    .N_ENTRY (N_ENTRY),
    .ISSUE_W (ISSUE_W),
    .GROUP_SZ(GROUP_SZ),
    .MAX_WAIT(MAX_WAIT),
    .IDXW    (IDXW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_en (issue_en),
    .gate_mode(gate_mode),
    .wait_ind (wait_ind),
    .req_vec  (req_vec),
    .prod_tag (prod_tag),
    .gnt_valid(gnt_valid),
    .gnt_idx  (gnt_idx)
);

// File: tb/tb_rws_issue_select.sv
module tb_rws_issue_select;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 8;
    localparam int NW = 6;
    localparam int IW = 3;
    localparam int NV = 12;

    typedef struct packed {
        logic [1:0]     mode;
        logic           en;
        logic [NW-1:0]  ind;
        logic [NE-1:0]  req;
        logic [NE-1:0]  typ;
        logic [NW-1:0]  v;
        logic [NW*IW-1:0] idx;
    } vec_t;

    // idx fields written {unit5, unit4, ..., unit0}
    localparam vec_t TBL [NV] = '{
        '{2'd0, 1'b1, 6'b000000, 8'hFF, 8'hFF, 6'b111111, {3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}}, // R4
        '{2'd0, 1'b1, 6'b000101, 8'hFF, 8'hFF, 6'b111010, {3'd3,3'd2,3'd1,3'd0,3'd0,3'd0}}, // R5
        '{2'd1, 1'b1, 6'b000101, 8'hFF, 8'h06, 6'b111111, {3'd5,3'd4,3'd2,3'd3,3'd1,3'd0}}, // R6
        '{2'd2, 1'b1, 6'b000000, 8'hFF, 8'hFF, 6'b010101, {3'd0,3'd2,3'd0,3'd1,3'd0,3'd0}}, // R7
        '{2'd2, 1'b1, 6'b000100, 8'hFF, 8'hF0, 6'b011111, {3'd0,3'd4,3'd3,3'd2,3'd1,3'd0}}, // R7
        '{2'd0, 1'b0, 6'b000000, 8'hFF, 8'hFF, 6'b000000, 18'd0},                           // R2
        '{2'd1, 1'b1, 6'b000000, 8'h00, 8'h00, 6'b000000, 18'd0},                           // R2
        '{2'd0, 1'b1, 6'b000000, 8'hA0, 8'h00, 6'b000011, {3'd0,3'd0,3'd0,3'd0,3'd7,3'd5}}, // R3
        '{2'd3, 1'b1, 6'b000001, 8'h0F, 8'hFF, 6'b011110, {3'd0,3'd3,3'd2,3'd1,3'd0,3'd0}}, // R5
        '{2'd1, 1'b1, 6'b111111, 8'hFF, 8'hFF, 6'b000000, 18'd0},                           // R6
        '{2'd0, 1'b1, 6'b111111, 8'hFF, 8'h00, 6'b000000, 18'd0},                           // R5
        '{2'd1, 1'b1, 6'b111111, 8'hFF, 8'h00, 6'b111111, {3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}}  // R6
    };
    localparam string TAGS [NV] = '{"R4", "R5", "R6", "R7", "R7", "R2",
                                    "R2", "R3", "R5", "R6", "R5", "R6"};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              issue_en = 1'b0;
    logic [1:0]        gate_mode = 2'd0;
    logic [NW-1:0]     wait_ind = '0;
    logic [NE-1:0]     req_vec = '0;
    logic [NE-1:0]     prod_tag = '0;
    logic [NW-1:0]     gnt_valid;
    logic [NW*IW-1:0]  gnt_idx;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rws_issue_select #(
        .N_ENTRY (NE),
        .ISSUE_W (NW),
        .GROUP_SZ(2),
        .MAX_WAIT(0)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_en (issue_en),
        .gate_mode(gate_mode),
        .wait_ind (wait_ind),
        .req_vec  (req_vec),
        .prod_tag (prod_tag),
        .gnt_valid(gnt_valid),
        .gnt_idx  (gnt_idx)
    );

    task automatic check(input string tag, input logic [NW-1:0] ev,
                         input logic [NW*IW-1:0] ei);
        total++;
        if (gnt_valid !== ev || gnt_idx !== ei) begin
            bad++;
            $display("FAIL %s valid=%b idx=%h expected valid=%b idx=%h",
                     tag, gnt_valid, gnt_idx, ev, ei);
        end
    endtask

    task automatic drive(input vec_t v);
        gate_mode = v.mode;
        issue_en  = v.en;
        wait_ind  = v.ind;
        req_vec   = v.req;
        prod_tag  = v.typ;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, outputs cleared while rst_n low
        drive(TBL[0]);
        repeat (3) @(negedge clk);
        check("R1 reset", '0, '0);
        rst_n = 1'b1;

        foreach (TBL[i]) begin
            @(negedge clk);
            drive(TBL[i]);
            @(negedge clk);
            check(TAGS[i], TBL[i].v, TBL[i].idx);
        end

        // R1: outputs hold between edges, then follow at the next edge
        @(negedge clk);
        drive(TBL[0]);
        @(negedge clk);
        check("R1 load", TBL[0].v, TBL[0].idx);
        issue_en = 1'b0;
        #(CLK_PERIOD/4);
        check("R1 hold", TBL[0].v, TBL[0].idx);
        @(negedge clk);
        check("R2 disabled", '0, '0);

        // R1: reset in mid-run clears grants
        issue_en = 1'b1;
        @(negedge clk);
        check("R1 reload", TBL[0].v, TBL[0].idx);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 midreset", '0, '0);
        rst_n = 1'b1;

        // R4: single request lands on unit 0 with the youngest entry
        wait_ind = '0; gate_mode = 2'd0; req_vec = 8'h80; prod_tag = 8'h80;
        @(negedge clk);
        check("R4 single", 6'b000001, {15'd0, 3'd7});

        // R7: pair budget restarts per group; slot-reuse allows two tags per idle pair
        gate_mode = 2'd1; req_vec = 8'hFF; prod_tag = 8'hFF; wait_ind = '0;
        @(negedge clk);
        check("R7 contrast", 6'b111111, {3'd5,3'd4,3'd3,3'd2,3'd1,3'd0});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule